// File: doc/BRIEF.md
# Prioritized Interrupt Collector

This block gathers up to fifteen interrupt sources, numbered 1 to 15, into one request line for a processor. Each source has a bit in four memory-mapped registers: a read-only pending register, a mask register, a write-one-to-clear register and a force register. A rising edge on a source input latches its pending bit. The block then offers the number of the highest unmasked pending source, together with the trap type the processor should take for it.

The source number is the bit position and also the priority, so source 15 wins over everything else. The trap type is the source number plus 0x10. Software can raise a source through the force register, but only while a test-enable bit is set. After the processor has taken a trap, it returns the serviced level on an acknowledge port, and that level's pending bit is cleared.

Typical source assignments are:
- 15: watchdog expiry
- 13: real-time clock tick
- 12: general timer
- 4 and 5: the two serial channels

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, every pending bit is 0 and mask bits 15..1 are all 1, so the mask register reads 0xFFFE. `irq_req` is 0, `irq_level` is 0 and `trap_type` is 0.
- R2: Only a rising edge on `src_in[n]` sets pending bit n. A source held high does not set the bit again after software has cleared it.
- R3: Mask bit n set to 1 blocks source n from the request outputs, though its pending bit still latches. Mask bit n set to 0 lets it through.
- R4: Writing the clear register at offset 0x50 clears each pending bit whose data bit is 1. Data bits of 0 leave the pending bits unchanged.
- R5: Writing a 1 to bit n of the force register at offset 0x54 sets pending bit n only while bit 19 of the test register at offset 0xD0 is 1. With that bit at 0, the write has no effect.
- R6: `irq_req` is 1 exactly when some unmasked pending bit is set. `irq_level` gives the highest such bit number, or 0 when there is none.
- R7: `trap_type` equals 0x10 plus `irq_level` while `irq_req` is 1, and is 0 otherwise.
- R8: A cycle with `ack_valid` high clears the pending bit numbered `ack_level`. An `ack_level` of 0 changes nothing.
- R9: When a set (edge or force) and a clear (clear register or acknowledge) hit the same pending bit in the same cycle, the bit ends up set.
- R10: Bit 0 is unused in every register. It reads 0, a source edge on it is ignored, and it cannot be written into the mask or forced.
- R11: Register offsets are:
  - pending at 0x48, read-only;
  - mask at 0x4C;
  - clear at 0x50, reads 0;
  - force at 0x54, reads 0;
  - test register at 0xD0, where only bit 19 is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| src_in | input | 16 | Source inputs; bit n is source n, bit 0 is ignored |
| ack_valid | input | 1 | Acknowledge strobe from the processor |
| ack_level | input | 4 | Level being acknowledged |
| irq_req | output | 1 | Request to the processor |
| irq_level | output | 4 | Highest unmasked pending source, or 0 |
| trap_type | output | 8 | Trap type for `irq_level` |

## Verification
The priority encoder is tried with three kinds of pending pattern:
- a single source, which shows that the level and trap type follow one bit;
- several simultaneous sources (3, 12 and 13), which shows that the highest number wins and that an acknowledge hands the request on to the next highest;
- sources that are pending but masked, which separates the pending state from the request.

Edge capture is tried in two ways. A one-cycle pulse is compared with a held level, which tells edge capture apart from level capture. A set and a clear are made to land on the same bit in the same cycle, which shows which of the two wins. Forcing is tried with the test bit off and then on, which shows that the gate really blocks the write.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    // Default register offsets (byte addresses)
    localparam logic [7:0] OFS_PEND_DEF  = 8'h48;
    localparam logic [7:0] OFS_MASK_DEF  = 8'h4C;
    localparam logic [7:0] OFS_CLR_DEF   = 8'h50;
    localparam logic [7:0] OFS_FRC_DEF   = 8'h54;
    localparam logic [7:0] OFS_TEST_DEF  = 8'hD0;

    // Which register a bus address selects
    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_PEND,
        RSEL_MASK,
        RSEL_CLR,
        RSEL_FRC,
        RSEL_TEST
    } regsel_e;

endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_prio_pkg::*;
#(
    parameter int         NSRC     = 15,
    parameter int         AW       = 8,
    parameter int         DW       = 32,
    parameter int         TEST_BIT = 19,
    parameter logic [7:0] OFS_PEND = OFS_PEND_DEF,
    parameter logic [7:0] OFS_MASK = OFS_MASK_DEF,
    parameter logic [7:0] OFS_CLR  = OFS_CLR_DEF,
    parameter logic [7:0] OFS_FRC  = OFS_FRC_DEF,
    parameter logic [7:0] OFS_TEST = OFS_TEST_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NSRC:0]   pend_i,
    output logic [NSRC:0]   mask_o,
    output logic            test_en_o,
    output logic [NSRC:0]   clr_vec_o,
    output logic [NSRC:0]   frc_vec_o
);

    localparam int VW = NSRC + 1;

    // Bit 0 is never a source
    localparam logic [NSRC:0] VALID = {{NSRC{1'b1}}, 1'b0};

    typedef struct packed {
        logic [NSRC:0] mask;
        logic          test_en;
    } rf_state_t;

    rf_state_t st_d, st_q;
    regsel_e   rsel;
    logic      wr;

    // Address decode
    always_comb begin
        rsel = RSEL_NONE;
        if (bus_addr == AW'(OFS_PEND)) rsel = RSEL_PEND;
        if (bus_addr == AW'(OFS_MASK)) rsel = RSEL_MASK;
        if (bus_addr == AW'(OFS_CLR))  rsel = RSEL_CLR;
        if (bus_addr == AW'(OFS_FRC))  rsel = RSEL_FRC;
        if (bus_addr == AW'(OFS_TEST)) rsel = RSEL_TEST;
    end

    assign wr = bus_sel && bus_we;

    // Next state, clear/force strobes and read data
    always_comb begin
        st_d      = st_q;
        clr_vec_o = '0;
        frc_vec_o = '0;
        bus_rdata = '0;

        if (wr) begin
            case (rsel)
                RSEL_MASK: st_d.mask    = bus_wdata[NSRC:0] & VALID;
                RSEL_TEST: st_d.test_en = bus_wdata[TEST_BIT];
                RSEL_CLR:  clr_vec_o    = bus_wdata[NSRC:0] & VALID;
                RSEL_FRC:  begin
                    if (st_q.test_en) frc_vec_o = bus_wdata[NSRC:0] & VALID;
                end
                default: ;
            endcase
        end

        if (bus_sel && !bus_we) begin
            case (rsel)
                RSEL_PEND: bus_rdata = DW'(pend_i & VALID);
                RSEL_MASK: bus_rdata = DW'(st_q.mask);
                RSEL_TEST: bus_rdata[TEST_BIT] = st_q.test_en;
                default:   bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mask    <= VALID;
            st_q.test_en <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o    = st_q.mask;
    assign test_en_o = st_q.test_en;

    // VW is kept for readability of derived widths
    logic [VW-1:0] unused_vw;
    assign unused_vw = '0;

endmodule

// File: rtl/irq_pend_capture.sv
module irq_pend_capture #(
    parameter int NSRC = 15,
    parameter int LVW  = $clog2(NSRC + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC:0]   src_i,
    input  logic [NSRC:0]   clr_vec_i,
    input  logic [NSRC:0]   frc_vec_i,
    input  logic            ack_valid,
    input  logic [LVW-1:0]  ack_level,
    output logic [NSRC:0]   pend_o,
    output logic [NSRC:0]   edge_o,
    output logic [NSRC:0]   set_vec_o
);

    typedef struct packed {
        logic [NSRC:0] src;
        logic [NSRC:0] pend;
    } cap_state_t;

    cap_state_t    st_d, st_q;
    logic [NSRC:0] ack_vec;
    logic [NSRC:0] kill_vec;

    // One-hot decode of the acknowledged level; bit 0 never decodes
    assign ack_vec[0] = 1'b0;
    for (genvar i = 1; i <= NSRC; i++) begin : g_ack
        assign ack_vec[i] = ack_valid && (ack_level == LVW'(i));
    end

    always_comb begin
        edge_o        = src_i & ~st_q.src;
        edge_o[0]     = 1'b0;
        set_vec_o     = edge_o | frc_vec_i;
        set_vec_o[0]  = 1'b0;
        kill_vec      = clr_vec_i | ack_vec;

        st_d.src      = src_i;
        // The set side is applied last, so it wins over a clear
        st_d.pend     = (st_q.pend & ~kill_vec) | set_vec_o;
        st_d.pend[0]  = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.src  <= '0;
            st_q.pend <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int NSRC = 15,
    parameter int LVW  = $clog2(NSRC + 1)
) (
    input  logic [NSRC:0]   pend_i,
    input  logic [NSRC:0]   mask_i,
    output logic            req_o,
    output logic [LVW-1:0]  level_o
);

    logic [NSRC:0] active;

    always_comb begin
        active    = pend_i & ~mask_i;
        active[0] = 1'b0;
        level_o   = '0;
        // Scan upward so the highest active number is the one kept
        for (int i = 1; i <= NSRC; i++) begin
            if (active[i]) level_o = LVW'(i);
        end
        req_o = |active;
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int         NSRC      = 15,
    parameter int         LVW       = $clog2(NSRC + 1),
    parameter int         AW        = 8,
    parameter int         DW        = 32,
    parameter int         TEST_BIT  = 19,
    parameter int         TTW       = 8,
    parameter logic [7:0] TRAP_BASE = 8'h10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NSRC:0]   src_in,
    input  logic            ack_valid,
    input  logic [LVW-1:0]  ack_level,
    output logic            irq_req,
    output logic [LVW-1:0]  irq_level,
    output logic [TTW-1:0]  trap_type
);

    logic [NSRC:0] pend_q;
    logic [NSRC:0] mask_q;
    logic          test_en;
    logic [NSRC:0] clr_vec;
    logic [NSRC:0] frc_vec;
    logic [NSRC:0] edge_vec;
    logic [NSRC:0] set_vec;

    irq_regfile #(
        .NSRC     (NSRC),
        .AW       (AW),
        .DW       (DW),
        .TEST_BIT (TEST_BIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pend_i    (pend_q),
        .mask_o    (mask_q),
        .test_en_o (test_en),
        .clr_vec_o (clr_vec),
        .frc_vec_o (frc_vec)
    );

    irq_pend_capture #(
        .NSRC (NSRC),
        .LVW  (LVW)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src_in),
        .clr_vec_i (clr_vec),
        .frc_vec_i (frc_vec),
        .ack_valid (ack_valid),
        .ack_level (ack_level),
        .pend_o    (pend_q),
        .edge_o    (edge_vec),
        .set_vec_o (set_vec)
    );

    irq_prio_enc #(
        .NSRC (NSRC),
        .LVW  (LVW)
    ) u_enc (
        .pend_i  (pend_q),
        .mask_i  (mask_q),
        .req_o   (irq_req),
        .level_o (irq_level)
    );

    assign trap_type = irq_req ? (TTW'(TRAP_BASE) + TTW'(irq_level)) : '0;

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter int NSRC = 15,
    parameter int LVW  = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC:0]   pend_q,
    input logic [NSRC:0]   mask_q,
    input logic            test_en,
    input logic [NSRC:0]   clr_vec,
    input logic [NSRC:0]   edge_vec,
    input logic [NSRC:0]   set_vec,
    input logic            ack_valid,
    input logic [LVW-1:0]  ack_level,
    input logic            irq_req,
    input logic [LVW-1:0]  irq_level
);

    logic [NSRC:0] active;
    assign active = pend_q & ~mask_q;

    // R3: the level offered is pending and not masked
    p_level_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (pend_q[irq_level] && !mask_q[irq_level]));

    // R6: nothing active above the offered level
    p_highest_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ((32'(active) >> (32'(irq_level) + 1)) == 0));

    // R4: a cleared bit with no concurrent set is gone next cycle
    p_clear_takes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec != 0) |=> ((pend_q & $past(clr_vec & ~set_vec)) == 0));

    // R5: without the test enable, new pending bits only come from edges
    p_force_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> ((pend_q & ~$past(pend_q) & ~$past(edge_vec)) == 0));

    // R8: an acknowledged level with no concurrent set is cleared
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_level != 0 && !set_vec[ack_level])
        |=> !pend_q[$past(ack_level)]);

    // R9: every set bit is pending in the next cycle
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != 0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
    .NSRC (NSRC),
    .LVW  (LVW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_q    (pend_q),
    .mask_q    (mask_q),
    .test_en   (test_en),
    .clr_vec   (clr_vec),
    .edge_vec  (edge_vec),
    .set_vec   (set_vec),
    .ack_valid (ack_valid),
    .ack_level (ack_level),
    .irq_req   (irq_req),
    .irq_level (irq_level)
);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;

    localparam logic [7:0] A_PEND = 8'h48;
    localparam logic [7:0] A_MASK = 8'h4C;
    localparam logic [7:0] A_CLR  = 8'h50;
    localparam logic [7:0] A_FRC  = 8'h54;
    localparam logic [7:0] A_TEST = 8'hD0;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_we;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [15:0] src_in;
    logic        ack_valid;
    logic [3:0]  ack_level;
    logic        irq_req;
    logic [3:0]  irq_level;
    logic [7:0]  trap_type;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5ns clk = ~clk;

    irq_prio_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_in    (src_in),
        .ack_valid (ack_valid),
        .ack_level (ack_level),
        .irq_req   (irq_req),
        .irq_level (irq_level),
        .trap_type (trap_type)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1ns;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse_src(input logic [15:0] v);
        src_in = v;
        @(negedge clk);
        src_in = '0;
    endtask

    task automatic do_ack(input logic [3:0] lvl);
        ack_valid = 1'b1; ack_level = lvl;
        @(negedge clk);
        ack_valid = 1'b0; ack_level = '0;
    endtask

    task automatic outputs_are(input string req, input logic r,
                               input logic [3:0] l, input logic [7:0] t);
        check(req, "irq_req", 32'(irq_req), 32'(r));
        check(req, "irq_level", 32'(irq_level), 32'(l));
        check(req, "trap_type", 32'(trap_type), 32'(t));
    endtask

    task automatic scrub();
        bus_write(A_TEST, 32'h0);
        bus_write(A_MASK, 32'hFFFF);
        bus_write(A_CLR, 32'hFFFF);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_read(A_PEND, d); check("R1", "pending after reset", d, 32'h0);
        bus_read(A_MASK, d); check("R1", "mask after reset", d, 32'hFFFE);
        outputs_are("R1", 1'b0, 4'd0, 8'h00);
        bus_read(A_TEST, d); check("R11", "test reg after reset", d, 32'h0);
    endtask

    task automatic t_single_masked();
        logic [31:0] d;
        scrub();
        pulse_src(16'h0010);
        bus_read(A_PEND, d); check("R3", "masked source latches", d, 32'h10);
        outputs_are("R3", 1'b0, 4'd0, 8'h00);
        bus_write(A_MASK, 32'hFFEF);
        outputs_are("R7", 1'b1, 4'd4, 8'h14);
        bus_write(A_CLR, 32'h0);
        bus_read(A_PEND, d); check("R4", "clear of zeros keeps pending", d, 32'h10);
        bus_write(A_CLR, 32'h0010);
        bus_read(A_PEND, d); check("R4", "clear of ones", d, 32'h0);
        outputs_are("R6", 1'b0, 4'd0, 8'h00);
    endtask

    task automatic t_level_hold();
        logic [31:0] d;
        scrub();
        bus_write(A_MASK, 32'h0);
        src_in = 16'h0020;
        @(negedge clk);
        bus_read(A_PEND, d); check("R2", "edge latches", d, 32'h20);
        bus_write(A_CLR, 32'h0020);
        repeat (3) @(negedge clk);
        bus_read(A_PEND, d); check("R2", "held source not relatched", d, 32'h0);
        src_in = '0;
        @(negedge clk);
    endtask

    task automatic t_priority();
        logic [31:0] d;
        scrub();
        bus_write(A_MASK, 32'h0);
        pulse_src(16'h3008);
        outputs_are("R6", 1'b1, 4'd13, 8'h1D);
        do_ack(4'd13);
        outputs_are("R8", 1'b1, 4'd12, 8'h1C);
        do_ack(4'd0);
        bus_read(A_PEND, d); check("R8", "ack of level 0 ignored", d, 32'h1008);
        do_ack(4'd12);
        outputs_are("R7", 1'b1, 4'd3, 8'h13);
        bus_write(A_MASK, 32'h0008);
        outputs_are("R3", 1'b0, 4'd0, 8'h00);
    endtask

    task automatic t_force();
        logic [31:0] d;
        scrub();
        bus_write(A_MASK, 32'h0);
        bus_write(A_FRC, 32'h8000);
        bus_read(A_PEND, d); check("R5", "force without test bit", d, 32'h0);
        outputs_are("R5", 1'b0, 4'd0, 8'h00);
        bus_write(A_TEST, 32'h0008_0000);
        bus_read(A_TEST, d); check("R11", "test bit readback", d, 32'h0008_0000);
        bus_write(A_FRC, 32'h8000);
        bus_read(A_PEND, d); check("R5", "force with test bit", d, 32'h8000);
        outputs_are("R5", 1'b1, 4'd15, 8'h1F);
        bus_read(A_FRC, d); check("R11", "force reads zero", d, 32'h0);
        bus_read(A_CLR, d); check("R11", "clear reads zero", d, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        scrub();
        src_in = 16'h0080;
        bus_write(A_CLR, 32'h0080);
        src_in = '0;
        bus_read(A_PEND, d); check("R9", "edge beats clear", d, 32'h80);
        bus_write(A_TEST, 32'h0008_0000);
        ack_valid = 1'b1; ack_level = 4'd7;
        bus_write(A_FRC, 32'h0080);
        ack_valid = 1'b0; ack_level = '0;
        bus_read(A_PEND, d); check("R9", "force beats ack", d, 32'h80);
    endtask

    task automatic t_bit0();
        logic [31:0] d;
        scrub();
        bus_write(A_MASK, 32'h0001);
        bus_read(A_MASK, d); check("R10", "mask bit 0 not stored", d, 32'h0);
        bus_write(A_TEST, 32'h0008_0000);
        bus_write(A_FRC, 32'h0001);
        pulse_src(16'h0001);
        bus_read(A_PEND, d); check("R10", "bit 0 never pending", d, 32'h0);
        outputs_are("R10", 1'b0, 4'd0, 8'h00);
    endtask

    initial begin
        rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0;
        bus_wdata = '0; src_in = '0; ack_valid = 1'b0; ack_level = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_masked();
        t_level_hold();
        t_priority();
        t_force();
        t_set_wins();
        t_bit0();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule